// File: doc/BRIEF.md
# Micro-Op Dispatch Port Scheduler

This block holds a sixteen-entry pool of waiting micro-ops and, on every clock, picks up to five of them for five execution ports. Port 0 is shared by the full-function integer unit and the floating-point unit. Port 1 feeds a reduced integer unit that only runs simple operations. Ports 2, 3 and 4 take loads, store-address and store-data micro-ops. Every pool entry runs a small state machine with three named states. `ENT_FREE` is an empty slot. `ENT_WAIT` holds a micro-op whose operands are not yet available. `ENT_RDY` holds a micro-op that may be dispatched. The transitions are: *alloc-wait* (`ENT_FREE` to `ENT_WAIT`), *alloc-ready* (`ENT_FREE` to `ENT_RDY`), *wake* (`ENT_WAIT` to `ENT_RDY`) and *issue* (`ENT_RDY` to `ENT_FREE`).

Operand tracking is outside the block. The surrounding logic writes one micro-op per cycle into the lowest free slot. It learns that slot number from `alloc_idx_o`. Later it marks the slot ready through the per-slot `wake_i` bit. Each port picks the oldest ready micro-op of its class, where age is the order of allocation and not the slot number. The chosen slots are reported on `grant_o` in the cycle they are picked and are freed at the next edge. Each port's dispatch then appears on the registered `dsp_*` outputs one cycle after its grant.

Top module: `dsp_port_sched`

## Requirements
- R1: After reset every slot is `ENT_FREE`, `rs_full_o` is 0, `grant_o` is 0, `alloc_idx_o` is 0 and every `dsp_vld_o` bit is 0.
- R2: With `alloc_vld_i` high and a free slot present, the micro-op is written into the lowest-numbered free slot, and that slot number is shown on `alloc_idx_o`. With all sixteen slots occupied, `rs_full_o` is 1 and an allocation attempt has no effect.
- R3: Only slots in `ENT_RDY` are granted. A slot enters `ENT_RDY` at allocation when `alloc_rdy_i` is 1, or at the edge after its `wake_i` bit is high while it is in `ENT_WAIT`. A micro-op is never granted in the cycle it is allocated.
- R4: Among the ready micro-ops eligible for a port, the one allocated earliest is chosen, whatever its slot number.
- R5: Port 0 takes the oldest ready micro-op of class complex-integer (code 0) or floating-point (code 2). `dsp_p0_fp_o` is 1 exactly when the micro-op dispatched on port 0 has class 2.
- R6: Port 1 takes only simple-integer micro-ops (code 1).
- R7: When no complex or floating-point micro-op is ready and two or more simple micro-ops are ready, port 0 takes the second-oldest simple micro-op, and port 1 takes the oldest.
- R8: Port 2 takes loads (code 3), port 3 takes store-address micro-ops (code 4) and port 4 takes store-data micro-ops (code 5).
- R9: `grant_o` is high for the picked slots in the cycle of the pick. Those slots are `ENT_FREE` after the next edge. At that edge, `dsp_vld_o[p]` and `dsp_tag_o[p*TAG_W +: TAG_W]` show the picked micro-op of port p.
- R10: A micro-op with class code 6 or 7 is never dispatched and keeps its slot occupied.
- R11: At most one micro-op is granted per port, so at most five per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld_i | input | 1 | Write a micro-op into the pool this cycle |
| alloc_cls_i | input | 3 | Class code of the new micro-op |
| alloc_tag_i | input | TAG_W | Identifier carried to the dispatch output |
| alloc_rdy_i | input | 1 | New micro-op is ready at once |
| wake_i | input | NUM_ENT | Per-slot ready strobe |
| alloc_idx_o | output | IDX_W | Slot that an allocation this cycle fills |
| rs_full_o | output | 1 | No free slot |
| grant_o | output | NUM_ENT | Slots picked this cycle |
| dsp_vld_o | output | 5 | Per-port dispatch valid, registered |
| dsp_p0_fp_o | output | 1 | Port 0 dispatch goes to the floating-point unit |
| dsp_tag_o | output | 5*TAG_W | Per-port dispatched tag, port p at bits p*TAG_W |

## Verification
The case that is hardest to reach is a younger micro-op sitting in a lower-numbered slot than an older one of the same class. Here slot order and age order disagree, and a picker based on index would still look correct on most stimulus. The bench builds this case on purpose. It allocates three waiting simple micro-ops, wakes and drains only the middle one, and refills the freed low slot with a fourth. It then wakes the rest together, so that the port 0 fallback must take the older higher-numbered slot. A long randomized phase checks every cycle against a behavioural model that orders entries by a plain allocation counter.

// File: rtl/dsp_sched_pkg.sv
package dsp_sched_pkg;

    // Micro-op class codes; codes 6 and 7 match no port.
    typedef enum logic [2:0] {
        UC_CPLX = 3'd0,
        UC_SIMP = 3'd1,
        UC_FP   = 3'd2,
        UC_LOAD = 3'd3,
        UC_STA  = 3'd4,
        UC_STD  = 3'd5
    } uop_cls_e;

    // Per-slot life cycle.
    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_RDY  = 2'd2
    } ent_state_e;

    localparam int NUM_PORTS = 5;
    localparam int PORT_INT0 = 0;
    localparam int PORT_INT1 = 1;
    localparam int PORT_LD   = 2;
    localparam int PORT_STA  = 3;
    localparam int PORT_STD  = 4;

endpackage

// File: rtl/dsp_rs_entry.sv
module dsp_rs_entry
    import dsp_sched_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             alloc_rdy_i,
    input  logic [2:0]       alloc_cls_i,
    input  logic [TAG_W-1:0] alloc_tag_i,
    input  logic             wake_i,
    input  logic             grant_i,
    output logic             busy_o,
    output logic             rdy_o,
    output logic [2:0]       cls_o,
    output logic [TAG_W-1:0] tag_o
);

    ent_state_e       state_q, state_d;
    logic [2:0]       cls_q;
    logic [TAG_W-1:0] tag_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    // Payload captured on the alloc-wait / alloc-ready transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= '0;
            tag_q <= '0;
        end else if (alloc_i && state_q == ENT_FREE) begin
            cls_q <= alloc_cls_i;
            tag_q <= alloc_tag_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: if (alloc_i) state_d = alloc_rdy_i ? ENT_RDY : ENT_WAIT;
            ENT_WAIT: if (wake_i)  state_d = ENT_RDY;
            ENT_RDY:  if (grant_i) state_d = ENT_FREE;
            default:               state_d = ENT_FREE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o = (state_q != ENT_FREE);
        rdy_o  = (state_q == ENT_RDY);
        cls_o  = cls_q;
        tag_o  = tag_q;
    end

endmodule

// File: rtl/dsp_age_matrix.sv
module dsp_age_matrix #(
    parameter int NUM_ENT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_ENT-1:0]         alloc_hit_i,
    output logic [NUM_ENT*NUM_ENT-1:0] older_o
);

    // older_q[i*NUM_ENT+j] set: slot i was allocated before slot j
    logic [NUM_ENT*NUM_ENT-1:0] older_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < NUM_ENT; i++) begin
                for (int j = 0; j < NUM_ENT; j++) begin
                    if (i != j) begin
                        if (alloc_hit_i[j])      older_q[i*NUM_ENT+j] <= 1'b1;
                        else if (alloc_hit_i[i]) older_q[i*NUM_ENT+j] <= 1'b0;
                    end
                end
            end
        end
    end

    assign older_o = older_q;

endmodule

// File: rtl/dsp_oldest_pick.sv
module dsp_oldest_pick #(
    parameter int NUM_ENT = 16
) (
    input  logic [NUM_ENT-1:0]         cand_i,
    input  logic [NUM_ENT*NUM_ENT-1:0] older_i,
    output logic [NUM_ENT-1:0]         win_o,
    output logic                       any_o
);

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        logic [NUM_ENT-1:0] beaten_by;
        for (genvar h = 0; h < NUM_ENT; h++) begin : g_col
            assign beaten_by[h] = older_i[h*NUM_ENT+g];
        end
        assign win_o[g] = cand_i[g] & ~|(cand_i & beaten_by);
    end

    assign any_o = |cand_i;

endmodule

// File: rtl/dsp_port_sched.sv
module dsp_port_sched
    import dsp_sched_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int TAG_W   = 6,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_vld_i,
    input  logic [2:0]                 alloc_cls_i,
    input  logic [TAG_W-1:0]           alloc_tag_i,
    input  logic                       alloc_rdy_i,
    input  logic [NUM_ENT-1:0]         wake_i,
    output logic [IDX_W-1:0]           alloc_idx_o,
    output logic                       rs_full_o,
    output logic [NUM_ENT-1:0]         grant_o,
    output logic [NUM_PORTS-1:0]       dsp_vld_o,
    output logic                       dsp_p0_fp_o,
    output logic [NUM_PORTS*TAG_W-1:0] dsp_tag_o
);

    logic [NUM_ENT-1:0]         ent_busy;
    logic [NUM_ENT-1:0]         ent_rdy;
    logic [2:0]                 ent_cls [NUM_ENT];
    logic [TAG_W-1:0]           ent_tag [NUM_ENT];
    logic [NUM_ENT-1:0]         alloc_oh;
    logic [NUM_ENT-1:0]         alloc_hit;
    logic [NUM_ENT*NUM_ENT-1:0] older;

    // Lowest free slot
    always_comb begin
        alloc_oh    = '0;
        alloc_idx_o = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!ent_busy[i]) begin
                alloc_oh    = '0;
                alloc_oh[i] = 1'b1;
                alloc_idx_o = IDX_W'(i);
            end
        end
    end

    assign rs_full_o = &ent_busy;
    assign alloc_hit = alloc_vld_i ? alloc_oh : '0;

    // Pool slots
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        dsp_rs_entry #(.TAG_W(TAG_W)) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (alloc_hit[g]),
            .alloc_rdy_i (alloc_rdy_i),
            .alloc_cls_i (alloc_cls_i),
            .alloc_tag_i (alloc_tag_i),
            .wake_i      (wake_i[g]),
            .grant_i     (grant_o[g]),
            .busy_o      (ent_busy[g]),
            .rdy_o       (ent_rdy[g]),
            .cls_o       (ent_cls[g]),
            .tag_o       (ent_tag[g])
        );
    end

    dsp_age_matrix #(.NUM_ENT(NUM_ENT)) u_age (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_hit_i (alloc_hit),
        .older_o     (older)
    );

    // Candidate sets per port (port 0 primary: complex or FP)
    logic [NUM_ENT-1:0] pick_cand [NUM_PORTS];
    logic [NUM_ENT-1:0] pick_win  [NUM_PORTS];
    logic [NUM_PORTS-1:0] pick_any;
    logic [NUM_ENT-1:0] fp_mask;

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            pick_cand[PORT_INT0][i] = ent_rdy[i] &&
                                      (ent_cls[i] == UC_CPLX || ent_cls[i] == UC_FP);
            pick_cand[PORT_INT1][i] = ent_rdy[i] && (ent_cls[i] == UC_SIMP);
            pick_cand[PORT_LD][i]   = ent_rdy[i] && (ent_cls[i] == UC_LOAD);
            pick_cand[PORT_STA][i]  = ent_rdy[i] && (ent_cls[i] == UC_STA);
            pick_cand[PORT_STD][i]  = ent_rdy[i] && (ent_cls[i] == UC_STD);
            fp_mask[i]              = (ent_cls[i] == UC_FP);
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pick
        dsp_oldest_pick #(.NUM_ENT(NUM_ENT)) u_pick (
            .cand_i  (pick_cand[p]),
            .older_i (older),
            .win_o   (pick_win[p]),
            .any_o   (pick_any[p])
        );
    end

    // Port 0 fallback: oldest simple micro-op left after port 1
    logic [NUM_ENT-1:0] alt_cand;
    logic [NUM_ENT-1:0] alt_win;
    logic               alt_any;

    assign alt_cand = pick_cand[PORT_INT1] & ~pick_win[PORT_INT1];

    dsp_oldest_pick #(.NUM_ENT(NUM_ENT)) u_pick_alt (
        .cand_i  (alt_cand),
        .older_i (older),
        .win_o   (alt_win),
        .any_o   (alt_any)
    );

    logic [NUM_ENT-1:0] port_win [NUM_PORTS];
    logic               p0_fp;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) port_win[p] = pick_win[p];
        if (!pick_any[PORT_INT0] && alt_any) port_win[PORT_INT0] = alt_win;
        p0_fp = |(pick_win[PORT_INT0] & fp_mask);
    end

    always_comb begin
        grant_o = '0;
        for (int p = 0; p < NUM_PORTS; p++) grant_o = grant_o | port_win[p];
    end

    // Tag of each port's winner
    logic [TAG_W-1:0] port_tag [NUM_PORTS];

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            port_tag[p] = '0;
            for (int i = 0; i < NUM_ENT; i++) begin
                if (port_win[p][i]) port_tag[p] = port_tag[p] | ent_tag[i];
            end
        end
    end

    // Registered dispatch outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsp_vld_o   <= '0;
            dsp_tag_o   <= '0;
            dsp_p0_fp_o <= 1'b0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                dsp_vld_o[p]                 <= |port_win[p];
                dsp_tag_o[p*TAG_W +: TAG_W]  <= port_tag[p];
            end
            dsp_p0_fp_o <= p0_fp;
        end
    end

endmodule

// File: rtl/dsp_sched_chk.sv
module dsp_sched_chk #(
    parameter int NUM_ENT = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_ENT-1:0] grant_o,
    input logic [NUM_ENT-1:0] ent_busy,
    input logic [NUM_ENT-1:0] ent_rdy,
    input logic [4:0]         dsp_vld_o,
    input logic               dsp_p0_fp_o,
    input logic               rs_full_o
);

    p_max_five_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) <= 5);

    p_grant_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~ent_rdy) == '0);

    p_disp_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(dsp_vld_o) == $countones($past(grant_o)));

    p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_full_o && grant_o == '0) |=> rs_full_o);

    p_fp_needs_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dsp_vld_o[0] |-> !dsp_p0_fp_o);

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_free
        p_freed_r9: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[g] |=> !ent_busy[g]);
    end

endmodule

bind dsp_port_sched dsp_sched_chk #(.NUM_ENT(NUM_ENT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_o     (grant_o),
    .ent_busy    (ent_busy),
    .ent_rdy     (ent_rdy),
    .dsp_vld_o   (dsp_vld_o),
    .dsp_p0_fp_o (dsp_p0_fp_o),
    .rs_full_o   (rs_full_o)
);

// File: tb/sim_dsp_port_sched.sv
module sim_dsp_port_sched;

    localparam int N  = 16;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_vld_i = 1'b0;
    logic [2:0]    alloc_cls_i = '0;
    logic [TW-1:0] alloc_tag_i = '0;
    logic          alloc_rdy_i = 1'b0;
    logic [N-1:0]  wake_i = '0;
    logic [3:0]    alloc_idx_o;
    logic          rs_full_o;
    logic [N-1:0]  grant_o;
    logic [4:0]    dsp_vld_o;
    logic          dsp_p0_fp_o;
    logic [5*TW-1:0] dsp_tag_o;

    always #2 clk = ~clk;

    dsp_port_sched #(.NUM_ENT(N), .TAG_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .alloc_vld_i(alloc_vld_i), .alloc_cls_i(alloc_cls_i),
        .alloc_tag_i(alloc_tag_i), .alloc_rdy_i(alloc_rdy_i), .wake_i(wake_i),
        .alloc_idx_o(alloc_idx_o), .rs_full_o(rs_full_o), .grant_o(grant_o),
        .dsp_vld_o(dsp_vld_o), .dsp_p0_fp_o(dsp_p0_fp_o), .dsp_tag_o(dsp_tag_o)
    );

    // Behavioural model: state 0 free, 1 waiting, 2 ready; age by counter
    int m_st [N];
    int m_cls [N];
    int m_tag [N];
    int m_seq [N];
    int seq_ctr = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string lbl, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", lbl, what, act, exp);
        end
    endtask

    function automatic int m_oldest(input bit [7:0] cmask, input int excl);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (m_st[i] == 2 && cmask[m_cls[i]] && i != excl)
                if (best < 0 || m_seq[i] < m_seq[best]) best = i;
        return best;
    endfunction

    function automatic logic [N-1:0] m_wait_all();
        logic [N-1:0] w = '0;
        for (int i = 0; i < N; i++) if (m_st[i] == 1) w[i] = 1'b1;
        return w;
    endfunction

    function automatic logic [N-1:0] m_wait_tag(input int t);
        logic [N-1:0] w = '0;
        for (int i = 0; i < N; i++) if (m_st[i] == 1 && m_tag[i] == t) w[i] = 1'b1;
        return w;
    endfunction

    // One clock: drive at falling edge, check grant, step model, check outputs
    task automatic cyc(input bit av, input int ac, input int at, input bit ar,
                       input logic [N-1:0] wk, input string lbl);
        int fr;
        int pk [5];
        logic [N-1:0] eg;
        bit efp;
        alloc_vld_i = av;
        alloc_cls_i = ac[2:0];
        alloc_tag_i = at[TW-1:0];
        alloc_rdy_i = ar;
        wake_i      = wk;
        #1;
        fr = -1;
        for (int i = N - 1; i >= 0; i--) if (m_st[i] == 0) fr = i;
        pk[0] = m_oldest(8'b0000_0101, -1);
        pk[1] = m_oldest(8'b0000_0010, -1);
        pk[2] = m_oldest(8'b0000_1000, -1);
        pk[3] = m_oldest(8'b0001_0000, -1);
        pk[4] = m_oldest(8'b0010_0000, -1);
        efp = (pk[0] >= 0) && (m_cls[pk[0]] == 2);
        if (pk[0] < 0 && pk[1] >= 0) pk[0] = m_oldest(8'b0000_0010, pk[1]);
        eg = '0;
        for (int p = 0; p < 5; p++) if (pk[p] >= 0) eg[pk[p]] = 1'b1;
        chk(grant_o == eg, lbl, "grant", grant_o, eg);
        chk(rs_full_o == (fr < 0), "R2", "rs_full", rs_full_o, (fr < 0));
        if (fr >= 0) chk(alloc_idx_o == fr[3:0], "R2", "alloc_idx", alloc_idx_o, fr);
        @(posedge clk);
        for (int p = 0; p < 5; p++) if (pk[p] >= 0) m_st[pk[p]] = 0;
        for (int i = 0; i < N; i++) if (wk[i] && m_st[i] == 1) m_st[i] = 2;
        if (av && fr >= 0) begin
            m_st[fr]  = ar ? 2 : 1;
            m_cls[fr] = ac;
            m_tag[fr] = at % 64;
            m_seq[fr] = seq_ctr;
            seq_ctr++;
        end
        @(negedge clk);
        for (int p = 0; p < 5; p++) begin
            chk(dsp_vld_o[p] == (pk[p] >= 0), lbl, $sformatf("vld port%0d", p),
                dsp_vld_o[p], (pk[p] >= 0));
            if (pk[p] >= 0)
                chk(dsp_tag_o[p*TW +: TW] == m_tag_hist(pk[p], p), lbl,
                    $sformatf("tag port%0d", p), dsp_tag_o[p*TW +: TW], m_tag_hist(pk[p], p));
        end
        chk(dsp_p0_fp_o == efp, "R5", "p0_fp", dsp_p0_fp_o, efp);
    endtask

    // Tag of a granted slot; the slot is never refilled in its grant cycle
    function automatic int m_tag_hist(input int idx, input int p);
        int unused = p;
        return m_tag[idx] + 0 * unused;
    endfunction

    task automatic idle(input string lbl, input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, '0, lbl);
    endtask

    task automatic wake(input logic [N-1:0] w, input string lbl);
        cyc(0, 0, 0, 0, w, lbl);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_cls[i] = 0; m_tag[i] = 0; m_seq[i] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(dsp_vld_o == '0, "R1", "dsp_vld", dsp_vld_o, 0);
        chk(grant_o == '0, "R1", "grant", grant_o, 0);
        chk(rs_full_o == 1'b0, "R1", "rs_full", rs_full_o, 0);
        chk(alloc_idx_o == '0, "R1", "alloc_idx", alloc_idx_o, 0);
        chk(dsp_p0_fp_o == 1'b0, "R1", "p0_fp", dsp_p0_fp_o, 0);
        @(negedge clk);

        // R3: waiting entry is held until woken
        cyc(1, 0, 1, 0, '0, "R3");
        idle("R3", 2);
        wake(m_wait_tag(1), "R3");
        idle("R3", 2);
        // R3: entry allocated ready is not granted in its allocation cycle
        cyc(1, 1, 2, 1, '0, "R3");
        idle("R3", 2);

        // R7: two simple micro-ops ready with port 0 otherwise idle
        cyc(1, 1, 10, 0, '0, "R7");
        cyc(1, 1, 11, 0, '0, "R7");
        cyc(1, 1, 12, 0, '0, "R7");
        wake(m_wait_all(), "R7");
        idle("R7", 3);

        // R4: younger entry in a lower slot than an older one
        cyc(1, 1, 20, 0, '0, "R4");
        cyc(1, 1, 21, 0, '0, "R4");
        cyc(1, 1, 22, 0, '0, "R4");
        wake(m_wait_tag(21), "R4");
        idle("R4", 2);
        cyc(1, 1, 23, 0, '0, "R4");
        wake(m_wait_all(), "R4");
        idle("R4", 3);

        // R5: complex and FP share port 0, oldest first
        cyc(1, 1, 30, 0, '0, "R5");
        cyc(1, 0, 31, 0, '0, "R5");
        cyc(1, 2, 32, 0, '0, "R5");
        cyc(1, 1, 33, 0, '0, "R5");
        cyc(1, 2, 34, 0, '0, "R5");
        wake(m_wait_all(), "R5");
        idle("R5", 4);

        // R6: port 1 stays idle with only complex and FP ready
        cyc(1, 0, 40, 0, '0, "R6");
        cyc(1, 2, 41, 0, '0, "R6");
        wake(m_wait_all(), "R6");
        idle("R6", 3);

        // R8 and R11: every port busy in one cycle
        cyc(1, 3, 50, 0, '0, "R8");
        cyc(1, 4, 51, 0, '0, "R8");
        cyc(1, 5, 52, 0, '0, "R8");
        cyc(1, 3, 53, 0, '0, "R8");
        cyc(1, 4, 54, 0, '0, "R8");
        cyc(1, 5, 55, 0, '0, "R8");
        cyc(1, 0, 56, 0, '0, "R8");
        cyc(1, 1, 57, 0, '0, "R8");
        wake(m_wait_all(), "R11");
        idle("R8", 3);

        // R10: class code 6 stays resident
        cyc(1, 6, 60, 1, '0, "R10");
        idle("R10", 3);
        cyc(1, 7, 61, 1, '0, "R10");
        idle("R10", 3);

        // R2: fill the pool, try one more, then drain
        for (int k = 0; k < 14; k++) cyc(1, 0, k, 0, '0, "R2");
        idle("R2", 1);
        cyc(1, 0, 63, 1, '0, "R2");
        idle("R2", 1);
        wake(m_wait_all(), "R2");
        idle("R2", 16);

        // R9: random traffic compared with the model every cycle
        for (int k = 0; k < 3000; k++) begin
            int cls;
            cls = $urandom_range(0, 5);
            cyc($urandom_range(0, 3) != 0, cls, k % 64, $urandom_range(0, 3) == 0,
                N'($urandom) & N'($urandom), "R9");
        end
        idle("R9", 20);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule